// File: doc/BRIEF.md
# Interrupt Bank Eligibility Filter

This block looks after one aligned bank of interrupt lines (32 by default) and reports, once per clock, which of them may be offered to a processor. It keeps a pending latch for every line. A line in edge mode sets its latch on a low-to-high transition. Software can set or clear any latch through per-line strobes.

The eligibility mask joins two sources: the latches, and the live level of every line in level mode. Lines that are disabled or already active are removed. Each line is then classed into one of three groups from its group bit and its modifier bit, and it survives only if the global enable for that group is on. A single-security-state control bit makes every modifier read as zero, so the secure Group 1 class merges into Group 0.

A priority selector downstream consumes the registered mask. That selector is not part of this block.

Top module: `irq_elig_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `pend_o` and `elig_o` are all zeros.
- R2: When a line has `trig_edge_i`=1 (edge mode) and `irq_i` goes from 0 to 1 between two clock edges, its bit in `pend_o` is 1 after the second edge.
- R3: A line with `trig_edge_i`=0 (level mode) never sets its latch from `irq_i`. While its input is high it still counts as pending for the mask, and once the input falls it stops counting.
- R4: A `sw_clr_i` bit clears that line's latch at the next edge when no set source for that line is present.
- R5: If a set source (`sw_set_i`, or a rising edge in edge mode) and `sw_clr_i` arrive for a line in the same cycle, the latch ends up set.
- R6: A line whose `enable_i` bit is 0, or whose `active_i` bit is 1, is never marked in `elig_o`.
- R7: A line with `group_i`=1 is eligible only when `en_g1ns_i` is 1.
- R8: A line with `group_i`=0 and `grp_mod_i`=1 is eligible only when `en_g1s_i` is 1, provided `single_sec_i` is 0.
- R9: A line with `group_i`=0 and `grp_mod_i`=0 is eligible only when `en_g0_i` is 1.
- R10: When `single_sec_i` is 1, every `grp_mod_i` bit is taken as 0, so every line with `group_i`=0 depends on `en_g0_i`.
- R11: `elig_o` is registered. After each edge it reflects the inputs sampled at that edge and the latch value produced by that same edge. It does not change between edges.
- R12: A latch holds its value when its line sees no set and no clear. In particular it stays set after an edge-mode input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Raw interrupt input levels |
| trig_edge_i | input | NUM_IRQ | 1 = edge mode, 0 = level mode |
| group_i | input | NUM_IRQ | Group bit per line |
| grp_mod_i | input | NUM_IRQ | Group modifier bit per line |
| enable_i | input | NUM_IRQ | Per-line enable |
| active_i | input | NUM_IRQ | Per-line active flag |
| sw_set_i | input | NUM_IRQ | Software set-pending strobes |
| sw_clr_i | input | NUM_IRQ | Software clear-pending strobes |
| en_g0_i | input | 1 | Group 0 enable |
| en_g1s_i | input | 1 | Secure Group 1 enable |
| en_g1ns_i | input | 1 | Non-secure Group 1 enable |
| single_sec_i | input | 1 | Single security state: modifiers read as 0 |
| pend_o | output | NUM_IRQ | Pending latch contents |
| elig_o | output | NUM_IRQ | Registered eligibility mask |

## Verification
Some properties can be checked every cycle from the ports, and the assertions cover those. They check that disabled or active lines never appear in the mask and that Group 1 lines never appear while their enable is off. They also check that a set strobe always wins over a clear, that an unopposed clear empties the latch, and that a latch never fills from a level-mode input. Other behaviour needs a directed sequence of stimulus, so only the bench scenarios can show it: the latch holding after an edge input falls, the secure Group 1 class collapsing into Group 0 under single-security mode, and the exact edge at which the mask reacts. A behavioural model then confirms every bit during a long random run.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

    // global group enables and security mode
    typedef struct packed {
        logic en_g0;
        logic en_g1s;
        logic en_g1ns;
        logic single_sec;
    } grp_ctrl_t;

    // line classification
    typedef enum logic [1:0] {
        CLS_G0   = 2'd0,
        CLS_G1S  = 2'd1,
        CLS_G1NS = 2'd2
    } grp_class_e;

    function automatic grp_class_e classify(input logic grp, input logic mod_eff);
        if (grp)          return CLS_G1NS;
        else if (mod_eff) return CLS_G1S;
        else              return CLS_G0;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] trig_edge_i,
    input  logic [NUM_IRQ-1:0] sw_set_i,
    input  logic [NUM_IRQ-1:0] sw_clr_i,
    output logic [NUM_IRQ-1:0] pend_next_o,
    output logic [NUM_IRQ-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] prev;
    } lat_state_t;

    lat_state_t st_d, st_q;
    logic [NUM_IRQ-1:0] rise;

    always_comb begin
        st_d = st_q;
        rise = irq_i & ~st_q.prev & trig_edge_i;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (rise[i] || sw_set_i[i]) begin
                st_d.pend[i] = 1'b1;
            end else if (sw_clr_i[i]) begin
                st_d.pend[i] = 1'b0;
            end
        end
        st_d.prev = irq_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_next_o = st_d.pend;
    assign pend_o      = st_q.pend;

endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate
    import irq_elig_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] group_i,
    input  logic [NUM_IRQ-1:0] grp_mod_i,
    input  grp_ctrl_t          ctrl_i,
    output logic [NUM_IRQ-1:0] grp_ok_o
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        grp_class_e cls;
        logic       mod_eff;

        assign mod_eff = grp_mod_i[g] & ~ctrl_i.single_sec;
        assign cls     = classify(group_i[g], mod_eff);

        always_comb begin
            unique case (cls)
                CLS_G1NS: grp_ok_o[g] = ctrl_i.en_g1ns;
                CLS_G1S:  grp_ok_o[g] = ctrl_i.en_g1s;
                default:  grp_ok_o[g] = ctrl_i.en_g0;
            endcase
        end
    end

endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
    import irq_elig_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] trig_edge_i,
    input  logic [NUM_IRQ-1:0] group_i,
    input  logic [NUM_IRQ-1:0] grp_mod_i,
    input  logic [NUM_IRQ-1:0] enable_i,
    input  logic [NUM_IRQ-1:0] active_i,
    input  logic [NUM_IRQ-1:0] sw_set_i,
    input  logic [NUM_IRQ-1:0] sw_clr_i,
    input  logic               en_g0_i,
    input  logic               en_g1s_i,
    input  logic               en_g1ns_i,
    input  logic               single_sec_i,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] elig_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] elig;
    } out_state_t;

    grp_ctrl_t          ctrl;
    logic [NUM_IRQ-1:0] pend_next;
    logic [NUM_IRQ-1:0] grp_ok;
    logic [NUM_IRQ-1:0] live;
    out_state_t         out_d, out_q;

    assign ctrl = '{en_g0: en_g0_i, en_g1s: en_g1s_i,
                    en_g1ns: en_g1ns_i, single_sec: single_sec_i};

    irq_pend_latch #(.NUM_IRQ(NUM_IRQ)) u_latch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .irq_i       (irq_i),
        .trig_edge_i (trig_edge_i),
        .sw_set_i    (sw_set_i),
        .sw_clr_i    (sw_clr_i),
        .pend_next_o (pend_next),
        .pend_o      (pend_o)
    );

    irq_group_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .group_i   (group_i),
        .grp_mod_i (grp_mod_i),
        .ctrl_i    (ctrl),
        .grp_ok_o  (grp_ok)
    );

    always_comb begin
        live       = pend_next | (irq_i & ~trig_edge_i);
        out_d.elig = live & enable_i & ~active_i & grp_ok;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign elig_o = out_q.elig;

endmodule

// File: rtl/irq_elig_bank_chk.sv
module irq_elig_bank_chk #(
    parameter int NUM_IRQ = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_IRQ-1:0] irq_i,
    input logic [NUM_IRQ-1:0] trig_edge_i,
    input logic [NUM_IRQ-1:0] group_i,
    input logic [NUM_IRQ-1:0] enable_i,
    input logic [NUM_IRQ-1:0] active_i,
    input logic [NUM_IRQ-1:0] sw_set_i,
    input logic [NUM_IRQ-1:0] sw_clr_i,
    input logic               en_g1ns_i,
    input logic [NUM_IRQ-1:0] pend_o,
    input logic [NUM_IRQ-1:0] elig_o
);

    // R6
    disabled_excluded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((elig_o & ~$past(enable_i)) == '0));

    // R6
    active_excluded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((elig_o & $past(active_i)) == '0));

    // R7
    g1ns_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_g1ns_i |=> ((elig_o & $past(group_i)) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((~pend_o & $past(sw_set_i)) == '0));

    // R4
    clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_o & $past(sw_clr_i & ~sw_set_i & ~irq_i)) == '0));

    // R3
    level_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(sw_set_i) & ~$past(trig_edge_i)) == '0));

endmodule

bind irq_elig_bank irq_elig_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .trig_edge_i (trig_edge_i),
    .group_i     (group_i),
    .enable_i    (enable_i),
    .active_i    (active_i),
    .sw_set_i    (sw_set_i),
    .sw_clr_i    (sw_clr_i),
    .en_g1ns_i   (en_g1ns_i),
    .pend_o      (pend_o),
    .elig_o      (elig_o)
);

// File: tb/tb_irq_elig_bank.sv
module tb_irq_elig_bank;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq = '0, trig = '0, grp = '0, gmod = '0;
    logic [N-1:0] en = '0, act = '0, sset = '0, sclr = '0;
    logic         g0 = 1'b0, g1s = 1'b0, g1ns = 1'b0, ssec = 1'b0;
    logic [N-1:0] pend, elig;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    bit m_pend [N];
    bit m_prev [N];
    bit m_mask [N];

    always #4 clk = ~clk;

    irq_elig_bank #(.NUM_IRQ(N)) dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .trig_edge_i(trig),
        .group_i(grp), .grp_mod_i(gmod), .enable_i(en), .active_i(act),
        .sw_set_i(sset), .sw_clr_i(sclr), .en_g0_i(g0), .en_g1s_i(g1s),
        .en_g1ns_i(g1ns), .single_sec_i(ssec), .pend_o(pend), .elig_o(elig)
    );

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_prev[i] = 0; m_mask[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                bit rise, np, live, ok;
                rise = trig[i] && irq[i] && !m_prev[i];
                if (rise || sset[i]) np = 1;
                else if (sclr[i])    np = 0;
                else                 np = m_pend[i];
                live = np || (!trig[i] && irq[i]);
                if (grp[i])                 ok = g1ns;
                else if (gmod[i] && !ssec)  ok = g1s;
                else                        ok = g0;
                m_mask[i] = live && en[i] && !act[i] && ok;
                m_pend[i] = np;
                m_prev[i] = irq[i];
            end
        end
    end

    task automatic chk(string req, logic [N-1:0] act_v, logic [N-1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic cmp_model();
        logic [N-1:0] ep, em;
        for (int i = 0; i < N; i++) begin
            ep[i] = m_pend[i];
            em[i] = m_mask[i];
        end
        chk({cur_req, " pend"}, pend, ep);
        chk({cur_req, " mask"}, elig, em);
    endtask

    // one clock, then compare at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
        sset = '0;
        sclr = '0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pend in reset", pend, '0);
        chk("R1 mask in reset", elig, '0);
        rst_n = 1'b1;
        en = '1; grp = '1; g1ns = 1'b1; trig = '1;
        tick();
        chk("R1 mask after reset", elig, '0);

        cur_req = "R2";
        irq[3] = 1'b1;
        tick();
        chk("R2 pend bit3", pend & 32'h8, 32'h8);
        chk("R2 mask bit3", elig & 32'h8, 32'h8);

        cur_req = "R12";
        irq[3] = 1'b0;
        tick();
        chk("R12 latch holds", pend & 32'h8, 32'h8);

        cur_req = "R4";
        sclr[3] = 1'b1;
        tick();
        chk("R4 cleared", pend, '0);

        cur_req = "R5";
        sset[5] = 1'b1; sclr[5] = 1'b1;
        irq[6] = 1'b1;  sclr[6] = 1'b1;
        tick();
        chk("R5 set beats clear", pend & 32'h60, 32'h60);
        sclr = 32'h60; irq[6] = 1'b0;
        tick();

        cur_req = "R3";
        trig[8] = 1'b0; irq[8] = 1'b1;
        tick();
        chk("R3 no latch", pend & 32'h100, '0);
        chk("R3 level counts", elig & 32'h100, 32'h100);
        irq[8] = 1'b0;
        tick();
        chk("R3 level gone", elig & 32'h100, '0);

        cur_req = "R6";
        sset[5] = 1'b1; en[5] = 1'b0;
        tick();
        chk("R6 disabled", elig & 32'h20, '0);
        en[5] = 1'b1; act[5] = 1'b1;
        tick();
        chk("R6 active", elig & 32'h20, '0);
        act[5] = 1'b0;

        cur_req = "R11";
        tick();
        en[5] = 1'b0;
        #1;
        chk("R11 no change before edge", elig & 32'h20, 32'h20);
        tick();
        chk("R11 change after edge", elig & 32'h20, '0);
        en[5] = 1'b1;

        cur_req = "R7";
        g1ns = 1'b0;
        tick();
        chk("R7 g1ns off", elig, '0);

        cur_req = "R8";
        grp[10] = 1'b0; gmod[10] = 1'b1; sset[10] = 1'b1; g1s = 1'b1; g0 = 1'b0;
        tick();
        chk("R8 g1s on", elig & 32'h400, 32'h400);
        g1s = 1'b0;
        tick();
        chk("R8 g1s off", elig & 32'h400, '0);

        cur_req = "R9";
        grp[11] = 1'b0; gmod[11] = 1'b0; sset[11] = 1'b1; g0 = 1'b0; g1s = 1'b1;
        tick();
        chk("R9 g0 off", elig & 32'h800, '0);
        g0 = 1'b1;
        tick();
        chk("R9 g0 on", elig & 32'h800, 32'h800);

        cur_req = "R10";
        ssec = 1'b1; g0 = 1'b0; g1s = 1'b1;
        tick();
        chk("R10 mod ignored off", elig & 32'h400, '0);
        g0 = 1'b1; g1s = 1'b0;
        tick();
        chk("R10 mod ignored on", elig & 32'h400, 32'h400);

        cur_req = "R11 random";
        for (int k = 0; k < 400; k++) begin
            irq  = $urandom; trig = $urandom; grp = $urandom; gmod = $urandom;
            en   = $urandom | $urandom; act = $urandom & $urandom;
            sset = $urandom & $urandom & $urandom; sclr = $urandom & $urandom;
            {g0, g1s, g1ns, ssec} = 4'($urandom);
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule